// File: doc/BRIEF.md
# Serial Memory Two-Wire Slave Engine

This block is the slave side of a two-wire serial memory. It runs entirely on the system clock. SCL and SDA are oversampled through synchronisers, and their edges and bus conditions are derived from the sampled values. After a START, the block takes in a select byte and compares it with a fixed type nibble and three strap inputs. For a write, it then collects a sixteen-bit address and stores any data bytes into an on-block synchronous RAM. For a read, it returns bytes from a persistent address counter for as long as the master keeps acknowledging.

The SDA output is an open-drain pull-down enable, so the pad logic outside the block does the actual driving. A write-protect strap blocks every data store while still letting the master set the address. Because the address counter persists across transfers, a read that follows a write or an earlier read continues from where the last transfer stopped. Setting the address with a write header followed by a repeated START gives a random read.

Top module: `i2c_mem_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Data is sampled on SCL rising edges. A START that arrives in the middle of a byte abandons that byte, and the following select byte is decoded normally.
- R2: The select byte is received MSB first. When bits 7..4 equal 1010b and bits 3..1 equal chip_en_i[2:0], the slave pulls SDA low during the 9th clock. Bit 0 is the direction: 1 means read, 0 means write.
- R3: When the select byte does not match, the slave gives no acknowledge and leaves SDA released for the rest of the transfer until the next START.
- R4: In a write, the two bytes after the select byte are the address, high byte first, and each is acknowledged. Address bits at and above MEM_AW are ignored, so 16'h8400 selects location 0 when MEM_AW is 10.
- R5: With wr_ctrl_i low, each data byte of a write is acknowledged and stored at the address counter, and the counter then advances by one. Several bytes in one transfer fill consecutive locations.
- R6: With wr_ctrl_i high, the select and address bytes are still acknowledged, but every data byte is left unacknowledged and the memory is not changed.
- R7: A read select with no address phase returns the byte at the address counter and then advances the counter.
- R8: A write select and two address bytes, followed by a repeated START and a read select with no STOP in between, return the byte at the address just loaded.
- R9: In a read, a master acknowledge in the 9th clock makes the slave send the next consecutive byte. A missing acknowledge makes it release SDA and wait for STOP or START.
- R10: The address counter wraps from the highest location (2**MEM_AW-1) to 0, both in writes and in sequential reads.
- R11: The SDA pull-down output changes only while SCL is low.
- R12: After reset, SDA is released. A STOP in the middle of a byte abandons the transfer and leaves the address counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| chip_en_i | input | 3 | Strap value the select bits 3..1 must match |
| wr_ctrl_i | input | 1 | Write protect: high blocks data stores |
| sda_oe_o | output | 1 | High to pull SDA low |

## Verification
The assertions assume a legal bus. Each SCL high or low phase must last several system clocks longer than the synchroniser latency. SDA may change while SCL is high only to form a START or a STOP, and neither condition may occur while the slave is pulling SDA low. The bench drives the master in quarter-bit steps of six clocks, changes its data only on the falling clock edge after SCL has gone low, and models the bus as the wired-AND of the master and the slave. The strap inputs and wr_ctrl_i are changed only between transfers.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_TX,
    ST_RACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/sync_ram.sv
module sync_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_mem_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        chip_en_i,
  input  logic              wr_ctrl_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              sda_oe_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o
);
  slv_state_e        st;
  logic [3:0]        bit_cnt;
  logic [7:0]        rx_sr, tx_sr, addr_hi;
  logic [MEM_AW-1:0] addr_cnt;
  logic              more;

  assign mem_addr_o = addr_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_IDLE;
      bit_cnt     <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      addr_hi     <= '0;
      addr_cnt    <= '0;
      more        <= 1'b0;
      sda_oe_o    <= 1'b0;
      mem_wdata_o <= '0;
      mem_we_o    <= 1'b0;
      mem_re_o    <= 1'b0;
    end else begin
      mem_we_o <= 1'b0;
      mem_re_o <= 1'b0;
      if (start_i) begin
        st       <= ST_DEV;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
            if (scl_rise_i && bit_cnt < 4'd8) begin
              rx_sr   <= {rx_sr[6:0], sda_s_i};
              bit_cnt <= bit_cnt + 4'd1;
              // prefetch as soon as the direction bit says read
              if (st == ST_DEV && bit_cnt == 4'd7 && sda_s_i) mem_re_o <= 1'b1;
            end else if (scl_fall_i && bit_cnt == 4'd8) begin
              bit_cnt <= 4'd9;
              unique case (st)
                ST_DEV: begin
                  if (rx_sr[7:1] == {DEV_TYPE, chip_en_i}) sda_oe_o <= 1'b1;
                  else begin
                    st      <= ST_IDLE;
                    bit_cnt <= '0;
                  end
                end
                ST_AHI: begin
                  addr_hi  <= rx_sr;
                  sda_oe_o <= 1'b1;
                end
                ST_ALO: begin
                  addr_cnt <= MEM_AW'({addr_hi, rx_sr});
                  sda_oe_o <= 1'b1;
                end
                default: begin
                  if (!wr_ctrl_i) begin
                    mem_we_o    <= 1'b1;
                    mem_wdata_o <= rx_sr;
                    sda_oe_o    <= 1'b1;
                  end
                end
              endcase
            end else if (scl_fall_i && bit_cnt == 4'd9) begin
              bit_cnt  <= '0;
              sda_oe_o <= 1'b0;
              unique case (st)
                ST_DEV: begin
                  if (rx_sr[0]) begin
                    st       <= ST_TX;
                    tx_sr    <= mem_rdata_i;
                    sda_oe_o <= ~mem_rdata_i[7];
                    addr_cnt <= addr_cnt + 1'b1;
                  end else st <= ST_AHI;
                end
                ST_AHI:  st <= ST_ALO;
                ST_ALO:  st <= ST_WR;
                default: if (sda_oe_o) addr_cnt <= addr_cnt + 1'b1;
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise_i) bit_cnt <= bit_cnt + 4'd1;
            else if (scl_fall_i) begin
              if (bit_cnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                st       <= ST_RACK;
              end else begin
                tx_sr    <= {tx_sr[6:0], 1'b0};
                sda_oe_o <= ~tx_sr[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              more     <= ~sda_s_i;
              mem_re_o <= ~sda_s_i;
            end else if (scl_fall_i) begin
              bit_cnt <= '0;
              if (more) begin
                st       <= ST_TX;
                tx_sr    <= mem_rdata_i;
                sda_oe_o <= ~mem_rdata_i[7];
                addr_cnt <= addr_cnt + 1'b1;
              end else st <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assert_sda_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s_i);

  assert_no_store_protected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !$past(wr_ctrl_i));

  assert_idle_released_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_oe_o);

  assert_ack_in_ninth_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> (bit_cnt == 4'd9 || st == ST_TX));

  assert_store_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (st == ST_WR && bit_cnt == 4'd9));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_en_i,
  input  logic       wr_ctrl_i,
  output logic       sda_oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic mem_we, mem_re;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_slave_fsm #(.MEM_AW(MEM_AW)) u_fsm (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .chip_en_i, .wr_ctrl_i, .mem_rdata_i(mem_rdata),
    .sda_oe_o, .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re)
  );

  sync_ram #(.AW(MEM_AW), .DW(8)) u_ram (
    .clk_i, .addr_i(mem_addr), .wdata_i(mem_wdata),
    .we_i(mem_we), .re_i(mem_re), .rdata_o(mem_rdata)
  );
endmodule

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, wr_ctrl = 1'b0;
  logic [2:0] chip_en = 3'b101;
  logic sda_oe, sda_bus;
  int n_tests = 0, n_fail = 0, viol = 0;
  logic prev_oe = 1'b0;

  localparam logic [7:0] SEL_W = 8'hAA;
  localparam logic [7:0] SEL_R = 8'hAB;

  always #4 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_mem_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .chip_en_i(chip_en), .wr_ctrl_i(wr_ctrl), .sda_oe_o(sda_oe)
  );

  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl) viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hq();
    repeat (6) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; hq(); scl = 1'b1; hq(); m_sda = 1'b0; hq(); scl = 1'b0; hq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hq(); scl = 1'b1; hq(); m_sda = 1'b1; hq();
  endtask

  task automatic wr_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq();
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    wr_bits(b, 8);
    m_sda = 1'b1; hq(); scl = 1'b1; hq();
    ack = (sda_bus == 1'b0);
    hq(); scl = 1'b0; hq();
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hq(); scl = 1'b1; hq();
      b[i] = sda_bus;
      hq(); scl = 1'b0; hq();
    end
    m_sda = ~mack; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq();
    m_sda = 1'b1;
  endtask

  task automatic send_addr(input logic [15:0] a, input string req);
    bit ack;
    i2c_start();
    wr_byte(SEL_W, ack);   chk(ack, req, "write select ack", ack, 1);
    wr_byte(a[15:8], ack); chk(ack, req, "addr high ack", ack, 1);
    wr_byte(a[7:0], ack);  chk(ack, req, "addr low ack", ack, 1);
  endtask

  task automatic read_sel(input string req);
    bit ack;
    i2c_start();
    wr_byte(SEL_R, ack); chk(ack, req, "read select ack", ack, 1);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R12", "sda released after reset", sda_oe, 0);
  endtask

  task automatic t_byte_write();
    bit ack;
    send_addr(16'h0010, "R2");
    wr_byte(8'hA5, ack); chk(ack, "R5", "data 0 ack", ack, 1);
    wr_byte(8'h5C, ack); chk(ack, "R5", "data 1 ack", ack, 1);
    i2c_stop();
  endtask

  task automatic t_page_write();
    bit ack;
    logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    send_addr(16'h0020, "R4");
    for (int i = 0; i < 4; i++) begin
      wr_byte(d[i], ack); chk(ack, "R5", "page data ack", ack, 1);
    end
    i2c_stop();
  endtask

  task automatic t_random_seq_read();
    logic [7:0] b;
    send_addr(16'h0020, "R8");
    read_sel("R8");
    rd_byte(1'b1, b); chk(b == 8'h11, "R8", "random read byte", b, 8'h11);
    rd_byte(1'b1, b); chk(b == 8'h22, "R9", "sequential byte 1", b, 8'h22);
    rd_byte(1'b0, b); chk(b == 8'h33, "R9", "sequential byte 2", b, 8'h33);
    chk(sda_oe == 1'b0, "R9", "released after nack", sda_oe, 0);
    hq();
    chk(sda_bus == 1'b1, "R9", "bus idle after nack", sda_bus, 1);
    i2c_stop();
  endtask

  task automatic t_current_read();
    logic [7:0] b;
    read_sel("R7");
    rd_byte(1'b0, b); chk(b == 8'h44, "R7", "current address byte", b, 8'h44);
    i2c_stop();
  endtask

  task automatic t_mismatch();
    bit ack;
    i2c_start();
    wr_byte(8'hA6, ack); chk(!ack, "R3", "wrong strap nack", ack, 0);
    wr_byte(8'h00, ack); chk(!ack, "R3", "ignored after mismatch", ack, 0);
    i2c_stop();
    i2c_start();
    wr_byte(8'hBA, ack); chk(!ack, "R3", "wrong type nack", ack, 0);
    i2c_stop();
  endtask

  task automatic t_write_ctrl();
    bit ack;
    wr_ctrl = 1'b1;
    send_addr(16'h0010, "R6");
    wr_byte(8'h5A, ack); chk(!ack, "R6", "protected data 0 nack", ack, 0);
    wr_byte(8'h5B, ack); chk(!ack, "R6", "protected data 1 nack", ack, 0);
    i2c_stop();
    wr_ctrl = 1'b0;
  endtask

  task automatic t_wrap();
    bit ack;
    logic [7:0] b;
    send_addr(16'h03FF, "R10");
    wr_byte(8'h77, ack); chk(ack, "R10", "last location ack", ack, 1);
    wr_byte(8'h88, ack); chk(ack, "R10", "wrapped location ack", ack, 1);
    i2c_stop();
    send_addr(16'h03FF, "R10");
    read_sel("R10");
    rd_byte(1'b1, b); chk(b == 8'h77, "R10", "read last location", b, 8'h77);
    rd_byte(1'b0, b); chk(b == 8'h88, "R10", "read wraps to 0", b, 8'h88);
    i2c_stop();
    send_addr(16'h8400, "R4");
    read_sel("R4");
    rd_byte(1'b0, b); chk(b == 8'h88, "R4", "upper address bits ignored", b, 8'h88);
    i2c_stop();
  endtask

  task automatic t_start_abort();
    logic [7:0] b;
    i2c_start();
    wr_bits(8'hF0, 4);
    send_addr(16'h0010, "R1");
    read_sel("R1");
    rd_byte(1'b0, b); chk(b == 8'hA5, "R6", "protected location kept", b, 8'hA5);
    i2c_stop();
  endtask

  task automatic t_stop_abort();
    bit ack;
    logic [7:0] b;
    i2c_start();
    wr_byte(SEL_W, ack); chk(ack, "R12", "select before abort", ack, 1);
    wr_byte(8'h00, ack); chk(ack, "R12", "addr high before abort", ack, 1);
    wr_bits(8'h00, 3);
    i2c_stop();
    read_sel("R12");
    rd_byte(1'b0, b); chk(b == 8'h5C, "R12", "counter kept across stop abort", b, 8'h5C);
    i2c_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_write();
    t_page_write();
    t_random_seq_read();
    t_current_read();
    t_mismatch();
    t_write_ctrl();
    t_wrap();
    t_start_abort();
    t_stop_abort();
    chk(viol == 0, "R11", "sda changes while scl high", viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule